// File: doc/BRIEF.md
# T1 Transmit Channel Conditioner

This block sits in the transmit path of a 24-channel T1 framer. It takes the outgoing serial NRZ payload one channel bit at a time, guided by strobes from an external frame timing generator (a bit-valid pulse, the channel number, the bit number within the channel and a signaling-frame flag). It conditions each 8-bit channel word before sending it on. A channel can be replaced with an idle code. A robbed signaling bit can be placed in the last bit of the word. An all-zero word can be stuffed so that the line keeps enough ones. Two global alarm patterns can be imposed on top of this.

Each channel is collected in full before it is sent. The zero-suppression test needs the final content of the whole word, after idle and signaling substitution. As a result the output stream lags the input by exactly one channel, which is eight bit-valid strobes. Framing bits and line coding are added further downstream. Only channel bits pass through this block.

Top module: `t1_tx_chan_cond`

## Requirements
- R1: After reset, `ser_out` is 0, and the eight bits sent during the first channel after reset are all 0.
- R2: Each channel word comes out unchanged when no feature applies to it. Bit 1 (`bit_idx`=0) is sent first. Each bit appears on `ser_out` in the cycle after the bit-valid strobe with the same `bit_idx` in the following channel. `ser_out` holds its value in cycles without a strobe.
- R3: A channel whose bit is set in `idle_mask` has its data replaced by an idle code. When `idle_ff`=0 the code is 7F hex: bit 1 is 0 and bits 2 to 8 are 1. When `idle_ff`=1 the code is FF hex: all ones.
- R4: When `sig_en`=1, `sig_frame`=1 and the channel's `sig_mask` bit is set, bit 8 of the word takes the value of `sig_in` sampled at that bit's strobe. `sig_in` has no effect at other bit times.
- R5: An idle channel still receives the signaling bit under the conditions of R4.
- R6: When `stuff_en`=1, a word whose final content is all zeros is sent with bit 7 (`bit_idx`=6) set to 1.
- R7: The all-zero test of R6 is applied after idle and signaling substitution. A zero data word whose signaling bit is 1 is therefore not stuffed.
- R8: A channel whose `clear_mask` bit is set gets neither signaling insertion nor bit-7 stuffing.
- R9: When `yellow_en`=1, bit 2 (`bit_idx`=1) of every word is forced to 0. This happens before the all-zero test of R6.
- R10: When `blue_en`=1, every bit sent is 1, whatever the data and the other modes.
- R11: Outside signaling frames (`sig_frame`=0), bit 8 carries the data or idle-code bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Strobe: one channel bit is present this cycle |
| chan_idx | input | CH_W (5) | Channel number, 0 to NUM_CH-1 |
| bit_idx | input | 3 | Bit within the channel, 0 = bit 1 (first) to 7 = bit 8 (last) |
| sig_frame | input | 1 | Current frame is a signaling frame |
| ser_in | input | 1 | Serial NRZ payload input |
| sig_in | input | 1 | Serial signaling input |
| idle_mask | input | NUM_CH | Channels replaced by idle code |
| clear_mask | input | NUM_CH | Transparent channels |
| sig_mask | input | NUM_CH | Channels carrying robbed-bit signaling |
| idle_ff | input | 1 | Idle code select: 0 = 7F, 1 = FF |
| sig_en | input | 1 | Global robbed-bit signaling enable |
| stuff_en | input | 1 | Global bit-7 zero suppression enable |
| yellow_en | input | 1 | Yellow alarm: bit 2 of every word forced to 0 |
| blue_en | input | 1 | Blue alarm: unframed all ones |
| ser_out | output | 1 | Conditioned serial NRZ output, one channel late |

## Verification
The hardest case to reach is a word that becomes all zeros only late in the chain. Examples are a word whose only 1 is in bit 2 while yellow alarm is active, and a zero word that is kept nonzero only by a signaling bit. Neither shows up in ordinary traffic. The stimulus builds each of them on purpose, one channel at a time, and changes the mode bits only in gap cycles between channels. This fixes which word each setting applies to. The bench then expects each word one channel later and checks every bit position.

// File: rtl/t1c_pkg.sv
`timescale 1ns/1ps
package t1c_pkg;
    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0]    chan_byte_t;
    typedef logic [BIT_IDX_W-1:0] bit_idx_t;

    // index 0 is bit 1, the first bit on the line
    localparam bit_idx_t   SIG_IDX   = bit_idx_t'(BYTE_W - 1);
    localparam int         STUFF_POS = BYTE_W - 2;
    localparam int         YEL_POS   = 1;
    localparam chan_byte_t IDLE_7F   = ~chan_byte_t'(1);

    typedef struct packed {
        chan_byte_t asm_b;
        chan_byte_t out_b;
        logic       ser;
    } cond_state_t;
endpackage

// File: rtl/t1c_bit_pick.sv
`timescale 1ns/1ps
module t1c_bit_pick
    import t1c_pkg::*;
#(
    parameter int NUM_CH = 24,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [CH_W-1:0]   chan_idx,
    input  bit_idx_t          bit_idx,
    input  logic              sig_frame,
    input  logic              ser_in,
    input  logic              sig_in,
    input  logic [NUM_CH-1:0] idle_mask,
    input  logic [NUM_CH-1:0] clear_mask,
    input  logic [NUM_CH-1:0] sig_mask,
    input  logic              idle_ff,
    input  logic              sig_en,
    output logic              bit_o,
    output logic              ch_clear
);
    logic       ch_ok;
    logic       ch_idle;
    logic       ch_sig;
    logic       rob;
    logic       data_bit;
    chan_byte_t idle_code;

    always_comb begin
        ch_ok     = (32'(chan_idx) < NUM_CH);
        ch_idle   = ch_ok && idle_mask[chan_idx];
        ch_clear  = ch_ok && clear_mask[chan_idx];
        ch_sig    = ch_ok && sig_mask[chan_idx];
        idle_code = idle_ff ? '1 : IDLE_7F;
        data_bit  = ch_idle ? idle_code[bit_idx] : ser_in;
        rob       = sig_en && sig_frame && ch_sig && !ch_clear && (bit_idx == SIG_IDX);
        bit_o     = rob ? sig_in : data_bit;
    end
endmodule

// File: rtl/t1c_byte_finish.sv
`timescale 1ns/1ps
module t1c_byte_finish
    import t1c_pkg::*;
(
    input  chan_byte_t raw,
    input  logic       stuff_en,
    input  logic       yellow_en,
    input  logic       ch_clear,
    output chan_byte_t fin
);
    always_comb begin
        fin = raw;
        if (yellow_en) begin
            fin[YEL_POS] = 1'b0;
        end
        if (stuff_en && !ch_clear && (fin == '0)) begin
            fin[STUFF_POS] = 1'b1;
        end
    end
endmodule

// File: rtl/t1_tx_chan_cond.sv
`timescale 1ns/1ps
module t1_tx_chan_cond
    import t1c_pkg::*;
#(
    parameter int NUM_CH = 24,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic [CH_W-1:0]   chan_idx,
    input  logic [2:0]        bit_idx,
    input  logic              sig_frame,
    input  logic              ser_in,
    input  logic              sig_in,
    input  logic [NUM_CH-1:0] idle_mask,
    input  logic [NUM_CH-1:0] clear_mask,
    input  logic [NUM_CH-1:0] sig_mask,
    input  logic              idle_ff,
    input  logic              sig_en,
    input  logic              stuff_en,
    input  logic              yellow_en,
    input  logic              blue_en,
    output logic              ser_out
);
    cond_state_t st_d, st_q;
    logic        in_bit;
    logic        ch_clear;
    chan_byte_t  full_b;
    chan_byte_t  fin_b;

    t1c_bit_pick #(.NUM_CH(NUM_CH)) u_pick (
        .chan_idx  (chan_idx),
        .bit_idx   (bit_idx),
        .sig_frame (sig_frame),
        .ser_in    (ser_in),
        .sig_in    (sig_in),
        .idle_mask (idle_mask),
        .clear_mask(clear_mask),
        .sig_mask  (sig_mask),
        .idle_ff   (idle_ff),
        .sig_en    (sig_en),
        .bit_o     (in_bit),
        .ch_clear  (ch_clear)
    );

    // the word completes with the bit arriving now in the last position
    assign full_b = {in_bit, st_q.asm_b[BYTE_W-2:0]};

    t1c_byte_finish u_fin (
        .raw      (full_b),
        .stuff_en (stuff_en),
        .yellow_en(yellow_en),
        .ch_clear (ch_clear),
        .fin      (fin_b)
    );

    always_comb begin
        st_d = st_q;
        if (bit_vld) begin
            st_d.asm_b[bit_idx] = in_bit;
            st_d.ser            = blue_en | st_q.out_b[bit_idx];
            if (bit_idx == SIG_IDX) begin
                st_d.out_b = fin_b;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_out = st_q.ser;

    // R10
    blue_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && blue_en) |=> ser_out);

    // R2
    hold_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(ser_out));

    // R6
    stuff_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && bit_idx == SIG_IDX && stuff_en && !ch_clear) |=> (st_q.out_b != '0));

    // R9
    yellow_bit2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && bit_idx == SIG_IDX && yellow_en) |=> !st_q.out_b[YEL_POS]);
endmodule

// File: tb/tb_t1_tx_chan_cond.sv
`timescale 1ns/1ps
module tb_t1_tx_chan_cond;
    localparam int NCH = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bit_vld = 1'b0;
    logic [4:0]      chan_idx = '0;
    logic [2:0]      bit_idx = '0;
    logic            sig_frame = 1'b0;
    logic            ser_in = 1'b0;
    logic            sig_in = 1'b0;
    logic [NCH-1:0]  idle_mask = '0;
    logic [NCH-1:0]  clear_mask = '0;
    logic [NCH-1:0]  sig_mask = '0;
    logic            idle_ff = 1'b0;
    logic            sig_en = 1'b0;
    logic            stuff_en = 1'b0;
    logic            yellow_en = 1'b0;
    logic            blue_en = 1'b0;
    logic            ser_out;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    bit    exp_bits[$];
    string exp_tag[$];

    always #4 clk = ~clk;

    t1_tx_chan_cond #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .chan_idx(chan_idx),
        .bit_idx(bit_idx), .sig_frame(sig_frame), .ser_in(ser_in), .sig_in(sig_in),
        .idle_mask(idle_mask), .clear_mask(clear_mask), .sig_mask(sig_mask),
        .idle_ff(idle_ff), .sig_en(sig_en), .stuff_en(stuff_en),
        .yellow_en(yellow_en), .blue_en(blue_en), .ser_out(ser_out)
    );

    function automatic logic [7:0] model(int ch, logic [7:0] d, logic sf, logic sb);
        logic [7:0] e;
        e = idle_mask[ch] ? (idle_ff ? 8'hFF : 8'b1111_1110) : d;
        if (sig_en && sf && sig_mask[ch] && !clear_mask[ch]) e[7] = sb;
        if (yellow_en) e[1] = 1'b0;
        if (stuff_en && !clear_mask[ch] && e == 8'h00) e[6] = 1'b1;
        return e;
    endfunction

    task automatic send_ch(input int ch, input logic [7:0] d, input logic sf,
                           input logic sb, input string tag);
        logic [7:0] e;
        e = model(ch, d, sf, sb);
        for (int i = 0; i < 8; i++) begin
            exp_bits.push_back(e[i]);
            exp_tag.push_back(tag);
        end
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            bit_vld   = 1'b1;
            chan_idx  = ch[4:0];
            bit_idx   = i[2:0];
            ser_in    = d[i];
            sig_frame = sf;
            sig_in    = (i == 7) ? sb : ~sb;
        end
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    logic  mon_blue;
    bit    mon_exp;
    string mon_tag;
    always @(posedge clk) begin
        if (bit_vld && rst_n) begin
            mon_blue = blue_en;
            @(negedge clk);
            checks++;
            if (exp_bits.size() == 0) begin
                errors++;
                $display("FAIL R2 output with empty scoreboard: actual %0b expected none", ser_out);
            end else begin
                mon_exp = exp_bits.pop_front();
                mon_tag = exp_tag.pop_front();
                if (mon_blue) begin
                    mon_exp = 1'b1;
                    mon_tag = "R10";
                end
                if (ser_out !== mon_exp) begin
                    errors++;
                    $display("FAIL %s ser_out actual %0b expected %0b", mon_tag, ser_out, mon_exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (ser_out !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset ser_out actual %0b expected 0", ser_out);
        end
        for (int i = 0; i < 8; i++) begin
            exp_bits.push_back(1'b0);
            exp_tag.push_back("R1");
        end
        // R2 plain data, bit 1 first, one channel late
        send_ch(0, 8'b1100_1010, 1'b0, 1'b0, "R2");
        send_ch(1, 8'b0011_1100, 1'b1, 1'b1, "R2");
        // R3 idle code in both forms
        idle_mask = 24'h00000C;
        send_ch(2, 8'h00, 1'b0, 1'b0, "R3");
        idle_ff = 1'b1;
        send_ch(3, 8'h00, 1'b0, 1'b0, "R3");
        idle_ff = 1'b0;
        // R4 signaling in bit 8, R11 none outside signaling frames
        sig_en = 1'b1;
        sig_mask = '1;
        send_ch(4, 8'hF0, 1'b1, 1'b0, "R4");
        send_ch(4, 8'h0F, 1'b1, 1'b1, "R4");
        send_ch(5, 8'hF0, 1'b0, 1'b0, "R11");
        // R5 idle channel still signals
        send_ch(2, 8'h55, 1'b1, 1'b0, "R5");
        // R6 stuffing
        stuff_en = 1'b1;
        send_ch(7, 8'h00, 1'b0, 1'b0, "R6");
        // R7 test after signaling substitution
        send_ch(8, 8'h00, 1'b1, 1'b1, "R7");
        // R8 transparent channel: no signaling, no stuffing
        clear_mask = 24'h000040;
        send_ch(6, 8'hF0, 1'b1, 1'b0, "R8");
        send_ch(6, 8'h00, 1'b0, 1'b0, "R8");
        // R9 yellow clears bit 2, then the zero test sees the result
        yellow_en = 1'b1;
        send_ch(9, 8'hFF, 1'b0, 1'b0, "R9");
        send_ch(10, 8'b0000_0010, 1'b0, 1'b0, "R9");
        send_ch(23, 8'h81, 1'b0, 1'b0, "R9");
        yellow_en = 1'b0;
        // R10 blue overrides the previous word
        blue_en = 1'b1;
        send_ch(0, 8'h00, 1'b0, 1'b0, "R10");
        send_ch(11, 8'h00, 1'b0, 1'b0, "R10");
        blue_en = 1'b0;
        send_ch(12, 8'h3A, 1'b0, 1'b0, "R2");
        send_ch(13, 8'h00, 1'b0, 1'b0, "R2");
        repeat (4) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule